// File: doc/BRIEF.md
# Peripheral Boot Download Controller

This block runs a boot-time download over a byte-serial link. On a start pulse it sends a fixed identification block to the host. It then waits, for a limited time, for a 32-bit command word. The command either asks for the identification block again, names another boot source, or opens a transfer. In a transfer the host first sends a 32-bit image length and then the image bytes. Each byte goes out on an internal RAM write port, at consecutive addresses above a fixed base.

Both the received byte stream and the transmitted byte stream use valid/ready handshakes. A millisecond tick input drives three separate time windows: one for the command, one for the image length and one for the image payload. Every run ends with a single-cycle completion pulse that carries an encoded verdict. The block then sits idle until the next start.

Top module: `pboot_loader`

## Requirements
- R1: After reset, and until start is pulsed, the block holds tx_valid, rx_ready, ram_we and done low.
- R2: After start, the block sends the 8-byte identification block once, in the order count byte (default 0x04), 0x01, 0x05, 0x01, 0x56, 0x41, channel byte, revision byte. Each byte is held stable until tx_ready accepts it.
- R3: The command 0xF0030003 makes the block send the identification block again and then keep waiting for a command. This works any number of times.
- R4: The command 0xF0030002 opens a transfer. Each image byte is written once to RAM at address RAM_BASE + n, where n is the byte index counted from 0. An execute verdict comes with the write of the final byte.
- R5: A command whose bits [31:16] are 0xF003 and whose bits [7:0] are 0x06 (and which is not a reserved code) ends the run with a change-device verdict. dev_code carries bits [15:8] of that command.
- R6: The command 0xFFFFFFFF ends the run with a next-device verdict. Any other value not named in R3 to R5 ends it with a memory-boot verdict.
- R7: If no complete command arrives within MSG_WAIT_MS ticks after the identification block, the run ends with a no-message verdict, and not before that many ticks.
- R8: A missing image length within SIZE_WAIT_MS ticks ends the run with an abort verdict. So does an incomplete payload within IMG_WAIT_MS ticks, and any bytes already accepted stay written.
- R9: An image length of zero ends the run with a skip verdict and no RAM write.
- R10: A length above MAX_IMG_BYTES ends the run with an abort verdict and no RAM write. A length equal to MAX_IMG_BYTES is loaded in full.
- R11: Command and length words are assembled from four bytes, least-significant byte first.
- R12: Each run produces exactly one single-cycle done pulse. The verdict codes are 0 execute, 1 skip, 2 abort, 3 change-device, 4 next-device, 5 memory-boot and 6 no-message. While a run is in progress, start has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begins a run when idle |
| ms_tick | input | 1 | One-cycle pulse per millisecond |
| rx_valid | input | 1 | Received byte valid |
| rx_data | input | 8 | Received byte |
| rx_ready | output | 1 | Block accepts a received byte |
| tx_valid | output | 1 | Transmit byte valid |
| tx_data | output | 8 | Transmit byte |
| tx_ready | input | 1 | Transmitter accepts the byte |
| ram_we | output | 1 | RAM write strobe |
| ram_addr | output | ADDR_W | RAM byte address |
| ram_wdata | output | 8 | RAM write data |
| done | output | 1 | One-cycle end-of-run pulse |
| verdict | output | 3 | Result code, valid with done |
| dev_code | output | 8 | Requested device from a change-device command |

## Verification
The bench builds the block with short windows: 6 ticks for the command, 8 for the length and 12 for the payload. This brings all three timeouts within a few hundred cycles. The maximum image length is set to 20 bytes, so the bench can write an image of exactly the limit length and reject one a byte longer. The revision byte is overridden to 0x01, which shows that the identification contents follow the parameters. The bench also holds tx_ready low at intervals to exercise transmit stalls.

// File: rtl/pboot_pkg.sv
package pboot_pkg;

  typedef enum logic [2:0] {
    V_EXECUTE = 3'd0,
    V_SKIP    = 3'd1,
    V_ABORT   = 3'd2,
    V_CHGDEV  = 3'd3,
    V_NEXTDEV = 3'd4,
    V_MEMBOOT = 3'd5,
    V_NOMSG   = 3'd6
  } verdict_t;

  typedef enum logic [2:0] {
    S_IDLE, S_SEND_ID, S_WAIT_MSG, S_WAIT_SIZE, S_LOAD
  } state_t;

  localparam int ID_LEN = 8;

  localparam logic [31:0] CMD_GET_ID = 32'hF003_0003;
  localparam logic [31:0] CMD_BOOT   = 32'hF003_0002;
  localparam logic [31:0] CMD_NEXT   = 32'hFFFF_FFFF;
  localparam logic [15:0] CMD_CHG_HI = 16'hF003;
  localparam logic [7:0]  CMD_CHG_LO = 8'h06;

  // Identification bytes in transmit order
  function automatic logic [7:0] id_byte(input int idx, input logic [7:0] cnt,
                                         input logic [7:0] chan, input logic [7:0] rev);
    case (idx)
      0:       return cnt;
      1:       return 8'h01;
      2:       return 8'h05;
      3:       return 8'h01;
      4:       return 8'h56;
      5:       return 8'h41;
      6:       return chan;
      default: return rev;
    endcase
  endfunction

endpackage

// File: rtl/pboot_id_tx.sv
module pboot_id_tx import pboot_pkg::*; #(
  parameter logic [7:0] ID_COUNT = 8'h04,
  parameter logic [7:0] ID_CHAN  = 8'h07,
  parameter logic [7:0] ID_REV   = 8'h02
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       go,
  output logic       tx_valid,
  output logic [7:0] tx_data,
  input  logic       tx_ready,
  output logic       fin
);
  localparam int IW = $clog2(ID_LEN);

  logic [7:0] rom [ID_LEN];
  logic [IW-1:0] idx;

  for (genvar g = 0; g < ID_LEN; g++) begin : g_rom
    assign rom[g] = id_byte(g, ID_COUNT, ID_CHAN, ID_REV);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_valid <= 1'b0;
      tx_data  <= 8'h00;
      idx      <= '0;
      fin      <= 1'b0;
    end else begin
      fin <= 1'b0;
      if (go) begin
        tx_valid <= 1'b1;
        tx_data  <= rom[0];
        idx      <= '0;
      end else if (tx_valid && tx_ready) begin
        if (idx == IW'(ID_LEN - 1)) begin
          tx_valid <= 1'b0;
          fin      <= 1'b1;
        end else begin
          idx     <= idx + 1'b1;
          tx_data <= rom[idx + 1'b1];
        end
      end
    end
  end
endmodule

// File: rtl/pboot_word_asm.sv
module pboot_word_asm (
  input  logic        clk,
  input  logic        rst,
  input  logic        clr,
  input  logic        byte_fire,
  input  logic [7:0]  byte_in,
  output logic        word_vld,
  output logic [31:0] word
);
  logic [1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt      <= '0;
      word     <= '0;
      word_vld <= 1'b0;
    end else begin
      word_vld <= 1'b0;
      if (byte_fire) begin
        word <= {byte_in, word[31:8]};
        cnt  <= cnt + 1'b1;
        if (cnt == 2'd3) word_vld <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/pboot_ms_timer.sv
module pboot_ms_timer #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          restart,
  input  logic          tick,
  input  logic [CW-1:0] limit,
  output logic          expired
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || restart)               cnt <= '0;
    else if (tick && cnt != limit)    cnt <= cnt + 1'b1;
  end

  assign expired = (cnt == limit);
endmodule

// File: rtl/pboot_loader.sv
module pboot_loader import pboot_pkg::*; #(
  parameter int          MSG_WAIT_MS   = 300,
  parameter int          SIZE_WAIT_MS  = 60000,
  parameter int          IMG_WAIT_MS   = 60000,
  parameter int          MAX_IMG_BYTES = 504 * 1024,
  parameter int          ADDR_W        = 32,
  parameter logic [31:0] RAM_BASE      = 32'h4030_0000,
  parameter logic [7:0]  ID_COUNT      = 8'h04,
  parameter logic [7:0]  ID_CHAN       = 8'h07,
  parameter logic [7:0]  ID_REV        = 8'h02
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              ms_tick,
  input  logic              rx_valid,
  input  logic [7:0]        rx_data,
  output logic              rx_ready,
  output logic              tx_valid,
  output logic [7:0]        tx_data,
  input  logic              tx_ready,
  output logic              ram_we,
  output logic [ADDR_W-1:0] ram_addr,
  output logic [7:0]        ram_wdata,
  output logic              done,
  output logic [2:0]        verdict,
  output logic [7:0]        dev_code
);
  localparam int TMAX_A = (MSG_WAIT_MS > SIZE_WAIT_MS) ? MSG_WAIT_MS : SIZE_WAIT_MS;
  localparam int TMAX   = (TMAX_A > IMG_WAIT_MS) ? TMAX_A : IMG_WAIT_MS;
  localparam int TW     = $clog2(TMAX + 1);
  localparam int RW     = $clog2(MAX_IMG_BYTES + 1);

  state_t            state;
  logic              id_go, id_fin;
  logic              word_vld;
  logic [31:0]       word;
  logic              asm_phase, asm_clr;
  logic              tmr_restart, tmr_expired, timeout;
  logic [TW-1:0]     tmr_limit;
  logic [RW-1:0]     remain;
  logic [ADDR_W-1:0] offset;

  pboot_id_tx #(.ID_COUNT(ID_COUNT), .ID_CHAN(ID_CHAN), .ID_REV(ID_REV)) u_id_tx (
    .clk(clk), .rst(rst), .go(id_go),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready), .fin(id_fin)
  );

  assign asm_phase = (state == S_WAIT_MSG) || (state == S_WAIT_SIZE);
  assign asm_clr   = (state == S_IDLE) || (state == S_SEND_ID);
  assign rx_ready  = (asm_phase && !word_vld) || (state == S_LOAD);

  pboot_word_asm u_asm (
    .clk(clk), .rst(rst), .clr(asm_clr),
    .byte_fire(rx_valid && rx_ready && asm_phase),
    .byte_in(rx_data), .word_vld(word_vld), .word(word)
  );

  always_comb begin
    case (state)
      S_WAIT_MSG:  tmr_limit = TW'(MSG_WAIT_MS);
      S_WAIT_SIZE: tmr_limit = TW'(SIZE_WAIT_MS);
      default:     tmr_limit = TW'(IMG_WAIT_MS);
    endcase
  end

  pboot_ms_timer #(.CW(TW)) u_tmr (
    .clk(clk), .rst(rst), .restart(tmr_restart), .tick(ms_tick),
    .limit(tmr_limit), .expired(tmr_expired)
  );

  // count is stale during the restart cycle
  assign timeout = tmr_expired && !tmr_restart;

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= S_IDLE;
      id_go       <= 1'b0;
      tmr_restart <= 1'b0;
      done        <= 1'b0;
      verdict     <= 3'd0;
      dev_code    <= 8'h00;
      ram_we      <= 1'b0;
      ram_addr    <= ADDR_W'(RAM_BASE);
      ram_wdata   <= 8'h00;
      remain      <= '0;
      offset      <= '0;
    end else begin
      id_go       <= 1'b0;
      tmr_restart <= 1'b0;
      done        <= 1'b0;
      ram_we      <= 1'b0;
      case (state)
        S_IDLE: begin
          if (start) begin
            state    <= S_SEND_ID;
            id_go    <= 1'b1;
            dev_code <= 8'h00;
          end
        end
        S_SEND_ID: begin
          if (id_fin) begin
            state       <= S_WAIT_MSG;
            tmr_restart <= 1'b1;
          end
        end
        S_WAIT_MSG: begin
          if (word_vld) begin
            if (word == CMD_GET_ID) begin
              state <= S_SEND_ID;
              id_go <= 1'b1;
            end else if (word == CMD_BOOT) begin
              state       <= S_WAIT_SIZE;
              tmr_restart <= 1'b1;
            end else if (word[31:16] == CMD_CHG_HI && word[7:0] == CMD_CHG_LO) begin
              dev_code <= word[15:8];
              verdict  <= V_CHGDEV;
              done     <= 1'b1;
              state    <= S_IDLE;
            end else begin
              verdict <= (word == CMD_NEXT) ? V_NEXTDEV : V_MEMBOOT;
              done    <= 1'b1;
              state   <= S_IDLE;
            end
          end else if (timeout) begin
            verdict <= V_NOMSG;
            done    <= 1'b1;
            state   <= S_IDLE;
          end
        end
        S_WAIT_SIZE: begin
          if (word_vld) begin
            if (word == 32'd0) begin
              verdict <= V_SKIP;
              done    <= 1'b1;
              state   <= S_IDLE;
            end else if (word > 32'(MAX_IMG_BYTES)) begin
              verdict <= V_ABORT;
              done    <= 1'b1;
              state   <= S_IDLE;
            end else begin
              remain      <= word[RW-1:0];
              offset      <= '0;
              state       <= S_LOAD;
              tmr_restart <= 1'b1;
            end
          end else if (timeout) begin
            verdict <= V_ABORT;
            done    <= 1'b1;
            state   <= S_IDLE;
          end
        end
        S_LOAD: begin
          if (rx_valid) begin
            ram_we    <= 1'b1;
            ram_addr  <= ADDR_W'(RAM_BASE) + offset;
            ram_wdata <= rx_data;
            offset    <= offset + 1'b1;
            remain    <= remain - 1'b1;
            if (remain == RW'(1)) begin
              verdict <= V_EXECUTE;
              done    <= 1'b1;
              state   <= S_IDLE;
            end
          end else if (timeout) begin
            verdict <= V_ABORT;
            done    <= 1'b1;
            state   <= S_IDLE;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pboot_loader_chk.sv
module pboot_loader_chk #(
  parameter int          ADDR_W        = 32,
  parameter logic [31:0] RAM_BASE      = 32'h4030_0000,
  parameter int          MAX_IMG_BYTES = 504 * 1024
) (
  input logic              clk,
  input logic              rst,
  input logic              tx_valid,
  input logic              tx_ready,
  input logic [7:0]        tx_data,
  input logic              rx_ready,
  input logic              ram_we,
  input logic [ADDR_W-1:0] ram_addr,
  input logic              done
);
  logic              have_prev;
  logic [ADDR_W-1:0] prev_addr;

  always_ff @(posedge clk) begin
    if (rst || done) begin
      have_prev <= 1'b0;
      prev_addr <= '0;
    end else if (ram_we) begin
      have_prev <= 1'b1;
      prev_addr <= ram_addr;
    end
  end

  // R2
  tx_hold_chk: assert property (@(posedge clk) disable iff (rst)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data));

  // R12
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R12
  done_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> !rx_ready && !tx_valid);

  // R4
  first_addr_chk: assert property (@(posedge clk) disable iff (rst)
    ram_we && !have_prev |-> ram_addr == ADDR_W'(RAM_BASE));

  // R4
  next_addr_chk: assert property (@(posedge clk) disable iff (rst)
    ram_we && have_prev |-> ram_addr == prev_addr + 1'b1);

  // R10
  addr_range_chk: assert property (@(posedge clk) disable iff (rst)
    ram_we |-> (ram_addr - ADDR_W'(RAM_BASE)) < ADDR_W'(MAX_IMG_BYTES));
endmodule

bind pboot_loader pboot_loader_chk #(
  .ADDR_W(ADDR_W), .RAM_BASE(RAM_BASE), .MAX_IMG_BYTES(MAX_IMG_BYTES)
) u_chk (
  .clk(clk), .rst(rst), .tx_valid(tx_valid), .tx_ready(tx_ready),
  .tx_data(tx_data), .rx_ready(rx_ready), .ram_we(ram_we),
  .ram_addr(ram_addr), .done(done)
);

// File: tb/test_pboot_loader.sv
module test_pboot_loader;
  localparam int          MSG_W  = 6;
  localparam int          SIZE_W = 8;
  localparam int          IMG_W  = 12;
  localparam int          MAXB   = 20;
  localparam logic [31:0] BASE   = 32'h4030_0000;

  logic clk = 0, rst = 1, start = 0, ms_tick = 0;
  logic rx_valid = 0, tx_ready = 0;
  logic [7:0] rx_data = 0;
  logic rx_ready, tx_valid, ram_we, done;
  logic [7:0] tx_data, ram_wdata, dev_code;
  logic [31:0] ram_addr;
  logic [2:0] verdict;

  always #5 clk = ~clk;

  pboot_loader #(.MSG_WAIT_MS(MSG_W), .SIZE_WAIT_MS(SIZE_W), .IMG_WAIT_MS(IMG_W),
                 .MAX_IMG_BYTES(MAXB), .ADDR_W(32), .RAM_BASE(BASE), .ID_REV(8'h01))
  i_pboot_loader (.clk, .rst, .start, .ms_tick, .rx_valid, .rx_data, .rx_ready,
                  .tx_valid, .tx_data, .tx_ready, .ram_we, .ram_addr, .ram_wdata,
                  .done, .verdict, .dev_code);

  int nchk = 0, nfail = 0, cyc = 0, tick_cnt = 0, done_cnt = 0, done_tick = 0;
  bit tick_en = 0;
  logic [2:0] last_v;
  logic [7:0] last_dev;
  logic [7:0] txq[$];
  logic [31:0] exp_addr[$];
  logic [7:0] exp_data[$];
  logic [7:0] id_exp [8] = '{8'h04, 8'h01, 8'h05, 8'h01, 8'h56, 8'h41, 8'h07, 8'h01};

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  endtask

  // stimulus pattern and reference monitor, evaluated every clock
  always @(negedge clk) begin
    cyc++;
    tx_ready = (cyc % 3) != 1;
    ms_tick  = tick_en && (cyc % 5 == 0);
    if (ms_tick) tick_cnt++;
    if (!rst) begin
      if (tx_valid && tx_ready) txq.push_back(tx_data);
      if (ram_we) begin
        if (exp_addr.size() == 0) check(0, "R4", "unexpected write addr", ram_addr, 0);
        else begin
          logic [31:0] ea; logic [7:0] ed;
          ea = exp_addr.pop_front(); ed = exp_data.pop_front();
          check(ram_addr == ea, "R4", "write addr", ram_addr, ea);
          check(ram_wdata == ed, "R4", "write data", ram_wdata, ed);
        end
      end
      if (done) begin
        done_cnt++; last_v = verdict; last_dev = dev_code; done_tick = tick_cnt;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog: actual hung expected finish");
    summary();
  end

  task automatic pulse_start();
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
  endtask

  task automatic send_byte(input logic [7:0] b);
    bit acc = 0;
    @(negedge clk); rx_valid = 1; rx_data = b;
    while (!acc) begin acc = rx_ready; @(negedge clk); end
    rx_valid = 0;
  endtask

  task automatic send_word(input logic [31:0] w);
    for (int i = 0; i < 4; i++) send_byte(w[8*i +: 8]);
  endtask

  task automatic expect_id(input string req);
    int n = 0;
    while (txq.size() < 8 && n < 500) begin @(negedge clk); n++; end
    check(txq.size() == 8, req, "id length", txq.size(), 8);
    for (int i = 0; i < 8 && i < txq.size(); i++)
      check(txq[i] == id_exp[i], req, $sformatf("id byte %0d", i), txq[i], id_exp[i]);
    txq.delete();
  endtask

  task automatic wait_done(input logic [2:0] ev, input string req);
    int base = done_cnt, n = 0;
    while (done_cnt == base && n < 2000) begin @(negedge clk); n++; end
    check(done_cnt == base + 1, req, "done seen", done_cnt - base, 1);
    check(last_v == ev, req, "verdict", last_v, ev);
    repeat (6) @(negedge clk);
    check(done_cnt == base + 1, "R12", "single done", done_cnt - base, 1);
    check(exp_addr.size() == 0, req, "writes pending", exp_addr.size(), 0);
    check(txq.size() == 0, "R12", "idle tx", txq.size(), 0);
  endtask

  task automatic begin_run(input string req);
    pulse_start();
    expect_id(req);
  endtask

  task automatic load(input int n, input int sent);
    for (int i = 0; i < sent; i++) begin
      exp_addr.push_back(BASE + i); exp_data.push_back(8'(8'hA0 + i));
    end
    for (int i = 0; i < sent; i++) send_byte(8'(8'hA0 + i));
  endtask

  initial begin
    int t0;
    repeat (4) @(negedge clk);
    rst = 0;
    tick_en = 1;
    // R1
    repeat (10) begin
      @(negedge clk);
      check(!tx_valid && !rx_ready && !ram_we && !done, "R1", "idle outputs",
            {tx_valid, rx_ready, ram_we, done}, 0);
    end
    // R2, R3, R12 start ignored, R4, R11
    begin_run("R2");
    send_word(32'hF003_0003); expect_id("R3");
    send_word(32'hF003_0003); expect_id("R3");
    pulse_start();
    repeat (5) @(negedge clk);
    check(txq.size() == 0, "R12", "start ignored while busy", txq.size(), 0);
    send_word(32'hF003_0002);
    send_word(32'd5);
    load(5, 5);
    wait_done(3'd0, "R4");
    // R5
    begin_run("R2");
    send_word(32'hF003_0A06);
    wait_done(3'd3, "R5");
    check(last_dev == 8'h0A, "R5", "device code", last_dev, 8'h0A);
    // R6
    begin_run("R2"); send_word(32'hFFFF_FFFF); wait_done(3'd4, "R6");
    begin_run("R2"); send_word(32'h1234_5678); wait_done(3'd5, "R6");
    begin_run("R2"); send_word(32'hF003_0005); wait_done(3'd5, "R6");
    // R7
    begin_run("R2");
    t0 = tick_cnt;
    wait_done(3'd6, "R7");
    check(done_tick - t0 >= MSG_W - 1 && done_tick - t0 <= MSG_W + 1, "R7",
          "ticks before timeout", done_tick - t0, MSG_W);
    // R9
    begin_run("R2"); send_word(32'hF003_0002); send_word(32'd0); wait_done(3'd1, "R9");
    // R10
    begin_run("R2"); send_word(32'hF003_0002); send_word(32'(MAXB + 1)); wait_done(3'd2, "R10");
    begin_run("R2"); send_word(32'hF003_0002); send_word(32'(MAXB)); load(MAXB, MAXB);
    wait_done(3'd0, "R10");
    // R8 size window
    begin_run("R2"); send_word(32'hF003_0002);
    t0 = tick_cnt;
    wait_done(3'd2, "R8");
    check(done_tick - t0 >= SIZE_W - 1, "R8", "size window ticks", done_tick - t0, SIZE_W);
    // R8 payload window
    begin_run("R2"); send_word(32'hF003_0002); send_word(32'd10); load(10, 3);
    t0 = tick_cnt;
    wait_done(3'd2, "R8");
    check(done_tick - t0 >= IMG_W - 2, "R8", "payload window ticks", done_tick - t0, IMG_W);
    summary();
  end
endmodule